// File: doc/BRIEF.md
# Dual-Slope Converter Sequencer

This block holds the digital half of a dual-slope integrating converter. A start request clears a four-decade BCD counter and routes the unknown input into an external integrator. The counter times a fixed integration window, then clears and is reused to measure how long the integrator takes to return to zero once it is switched onto the negative reference. Counting is gated by an external comparator. When the comparator drops, the count is frozen as the result and a one-cycle done pulse is issued. The integrator is then discharged for a short zero phase before the next conversion can begin.

The result stays in BCD so a display driver can use it directly. With a 1000-count window and a reference equal in size to 1000 counts of input slope, an input worth 5000 counts reads back as 5000. A display that places its decimal point after the most significant digit shows this as 5.000.

Top module: `dslope_seq`

## Requirements
- R1: After reset the block is idle. busy_o, done_o, ovf_o, sel_in_o and sel_ref_o are low, result_o is zero and int_rst_o is high.
- R2: A start_i seen while idle makes the block busy on the next cycle. In that cycle sel_in_o is high, int_rst_o is low, result_o is zero and ovf_o is clear.
- R3: sel_in_o stays high for exactly T_INT cycles. sel_ref_o then rises in the cycle after sel_in_o falls.
- R4: The comparator passes through a two-stage synchronizer. During de-integration the first two cycles are spent settling, and after that the counter advances once per cycle while the synchronized comparator is high. An integrator that ramps up by V per input cycle and down by T_INT per reference cycle therefore yields a result of V.
- R5: The first settled cycle with the synchronized comparator low ends de-integration. done_o is then high for exactly one cycle, and result_o is valid in that cycle. This includes an input of zero, which reads 0.
- R6: If the counter is at 9999 and the synchronized comparator is still high, ovf_o is set, result_o stays at 9999 and the conversion ends with a done_o pulse.
- R7: After done_o rises, busy_o and int_rst_o stay high for ZERO_CYC cycles, counting the done cycle. The block then returns to idle.
- R8: A start_i while busy_o is high is ignored, so the result of the conversion in progress is unchanged.
- R9: While idle and without a start request, result_o and ovf_o hold their values whatever the comparator does.
- R10: result_o is BCD. Digit d occupies bits 4d+3..4d, digit 0 is the least significant, and every digit is in the range 0..9.
- R11: sel_in_o and sel_ref_o are never high together, and neither is high while int_rst_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Conversion request |
| cmp_i | input | 1 | Comparator, high while the integrator is away from zero |
| sel_in_o | output | 1 | Routes the unknown input to the integrator |
| sel_ref_o | output | 1 | Routes the negative reference to the integrator |
| int_rst_o | output | 1 | Discharges the integrator |
| busy_o | output | 1 | Conversion or zero phase in progress |
| done_o | output | 1 | One-cycle end-of-conversion pulse |
| ovf_o | output | 1 | Count exceeded 9999 |
| result_o | output | 4*DIGITS | BCD conversion result |

## Verification
busy_o and sel_in_o are due one cycle after the edge that samples start_i. sel_ref_o follows T_INT cycles later. done_o arrives V+3 cycles after sel_ref_o rises: two settling cycles, V counting cycles and the cycle that sees the comparator low. The bench models the integrator with register-true timing, drives inputs and samples outputs on the falling clock edge, and waits for done_o rather than assuming a fixed delay. At each done_o it checks the value against the arithmetic expectation, then counts busy cycles to confirm the zero phase.

// File: rtl/dslope_seq.sv
module dslope_seq #(
  parameter int DIGITS   = 4,
  parameter int T_INT    = 1000,
  parameter int ZERO_CYC = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start_i,
  input  logic                  cmp_i,
  output logic                  sel_in_o,
  output logic                  sel_ref_o,
  output logic                  int_rst_o,
  output logic                  busy_o,
  output logic                  done_o,
  output logic                  ovf_o,
  output logic [4*DIGITS-1:0]   result_o
);
  localparam int W    = 4 * DIGITS;
  localparam int SYNC = 2;
  localparam int AUXW = $clog2(ZERO_CYC + SYNC + 1);

  function automatic logic [W-1:0] to_bcd(input int v);
    logic [W-1:0] r;
    int t;
    t = v;
    r = '0;
    for (int d = 0; d < DIGITS; d++) begin
      r[4*d +: 4] = 4'(t % 10);
      t = t / 10;
    end
    return r;
  endfunction

  localparam logic [W-1:0] TC = to_bcd(T_INT - 1);

  typedef enum logic [1:0] {S_IDLE, S_INT, S_DEINT, S_ZERO} st_t;
  st_t st;

  logic [SYNC-1:0] cs;
  logic            cmp_s;
  logic [W-1:0]    cnt, cnt_inc;
  logic [DIGITS:0] cy;
  logic [AUXW-1:0] aux;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) cs <= '0;
    else        cs <= {cs[SYNC-2:0], cmp_i};
  assign cmp_s = cs[SYNC-1];

  assign cy[0] = 1'b1;
  for (genvar d = 0; d < DIGITS; d++) begin : g_dec
    logic nine;
    assign nine            = cnt[4*d +: 4] == 4'd9;
    assign cnt_inc[4*d +: 4] = cy[d] ? (nine ? 4'd0 : cnt[4*d +: 4] + 4'd1) : cnt[4*d +: 4];
    assign cy[d+1]         = cy[d] & nine;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      cnt    <= '0;
      aux    <= '0;
      done_o <= 1'b0;
      ovf_o  <= 1'b0;
    end else begin
      done_o <= 1'b0;
      case (st)
        S_IDLE: if (start_i) begin
          cnt   <= '0;
          ovf_o <= 1'b0;
          st    <= S_INT;
        end
        S_INT: if (cnt == TC) begin
          cnt <= '0;
          aux <= '0;
          st  <= S_DEINT;
        end else cnt <= cnt_inc;
        S_DEINT: if (aux < AUXW'(SYNC)) aux <= aux + 1'b1;
        else if (!cmp_s || cy[DIGITS]) begin
          ovf_o  <= cmp_s;
          done_o <= 1'b1;
          aux    <= '0;
          st     <= S_ZERO;
        end else cnt <= cnt_inc;
        default: if (aux == AUXW'(ZERO_CYC - 1)) st <= S_IDLE;
        else aux <= aux + 1'b1;
      endcase
    end
  end

  assign sel_in_o  = st == S_INT;
  assign sel_ref_o = st == S_DEINT;
  assign int_rst_o = st == S_IDLE || st == S_ZERO;
  assign busy_o    = st != S_IDLE;
  assign result_o  = cnt;
endmodule

// File: rtl/dslope_seq_chk.sv
module dslope_seq_chk #(
  parameter int DIGITS = 4
) (
  input logic                clk,
  input logic                rst_n,
  input logic                start_i,
  input logic                sel_in_o,
  input logic                sel_ref_o,
  input logic                int_rst_o,
  input logic                busy_o,
  input logic                done_o,
  input logic                ovf_o,
  input logic [4*DIGITS-1:0] result_o
);
  function automatic logic digits_ok(input logic [4*DIGITS-1:0] v);
    logic ok;
    ok = 1'b1;
    for (int d = 0; d < DIGITS; d++) if (v[4*d +: 4] > 4'd9) ok = 1'b0;
    return ok;
  endfunction

  function automatic logic all_nine(input logic [4*DIGITS-1:0] v);
    logic ok;
    ok = 1'b1;
    for (int d = 0; d < DIGITS; d++) if (v[4*d +: 4] != 4'd9) ok = 1'b0;
    return ok;
  endfunction

  a_r10_bcd_digits: assert property (@(posedge clk) disable iff (!rst_n) digits_ok(result_o));
  a_r11_sel_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(sel_in_o && sel_ref_o) && !(int_rst_o && (sel_in_o || sel_ref_o)));
  a_r2_start_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && start_i) |=> (busy_o && sel_in_o && !int_rst_o && result_o == '0 && !ovf_o));
  a_r5_done_pulse: assert property (@(posedge clk) disable iff (!rst_n) done_o |=> !done_o);
  a_r5_done_after_ref: assert property (@(posedge clk) disable iff (!rst_n) done_o |-> $past(sel_ref_o));
  a_r6_ovf_nines: assert property (@(posedge clk) disable iff (!rst_n) ovf_o |-> all_nine(result_o));
  a_r7_zero_phase: assert property (@(posedge clk) disable iff (!rst_n) done_o |-> (busy_o && int_rst_o));
  a_r9_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !start_i) |=> ($stable(result_o) && $stable(ovf_o)));
endmodule

bind dslope_seq dslope_seq_chk #(.DIGITS(DIGITS)) u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .sel_in_o(sel_in_o),
  .sel_ref_o(sel_ref_o), .int_rst_o(int_rst_o), .busy_o(busy_o),
  .done_o(done_o), .ovf_o(ovf_o), .result_o(result_o)
);

// File: tb/test_dslope_seq.sv
module test_dslope_seq;
  localparam int DIGITS   = 4;
  localparam int T_INT    = 1000;
  localparam int ZERO_CYC = 8;
  localparam int W        = 4 * DIGITS;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0;
  logic cmp_i;
  logic cmp_force = 1'b0;
  logic sel_in_o, sel_ref_o, int_rst_o, busy_o, done_o, ovf_o;
  logic [W-1:0] result_o;

  longint acc = 0;
  int     vin = 0;
  int     checks = 0;
  int     fails = 0;
  int     cycles = 0;

  always #5 clk = ~clk;

  dslope_seq #(.DIGITS(DIGITS), .T_INT(T_INT), .ZERO_CYC(ZERO_CYC)) i_dslope_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .cmp_i(cmp_i),
    .sel_in_o(sel_in_o), .sel_ref_o(sel_ref_o), .int_rst_o(int_rst_o),
    .busy_o(busy_o), .done_o(done_o), .ovf_o(ovf_o), .result_o(result_o)
  );

  always_ff @(posedge clk)
    if (int_rst_o)      acc <= 0;
    else if (sel_in_o)  acc <= acc + longint'(vin);
    else if (sel_ref_o) acc <= acc - longint'(T_INT);
  assign cmp_i = (acc > 0) || cmp_force;

  function automatic logic [W-1:0] bcd(input int v);
    logic [W-1:0] r;
    int t;
    t = v;
    for (int d = 0; d < DIGITS; d++) begin
      r[4*d +: 4] = 4'(t % 10);
      t = t / 10;
    end
    return r;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected<190000", cycles);
      finish_run();
    end
  end

  task automatic convert(input int v, input bit extra_start);
    int n_in, n_busy, exp_res;
    bit both;
    vin = v;
    n_in = 0;
    both = 0;
    @(negedge clk);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    check("R2 busy", busy_o, 1);
    check("R2 result cleared", result_o, 0);
    while (!done_o) begin
      if (sel_in_o) n_in++;
      if (sel_in_o && sel_ref_o) both = 1;
      if (extra_start && n_in == 10) start_i = 1'b1;
      if (extra_start && n_in == 12) start_i = 1'b0;
      @(negedge clk);
    end
    start_i = 1'b0;
    exp_res = (v > 9999) ? 9999 : v;
    check("R3 integration cycles", n_in, T_INT);
    check("R11 selects exclusive", both, 0);
    check(extra_start ? "R8 result with extra start" : "R4 result", result_o, bcd(exp_res));
    check("R6 overflow flag", ovf_o, (v > 9999) ? 1 : 0);
    n_busy = 0;
    while (busy_o) begin
      n_busy++;
      if (!int_rst_o) both = 1;
      @(negedge clk);
      if (n_busy == 1) check("R5 done single cycle", done_o, 0);
    end
    check("R7 zero phase length", n_busy, ZERO_CYC);
    check("R7 integrator reset in zero phase", both, 0);
    check("R9 result held", result_o, bcd(exp_res));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 busy", busy_o, 0);
    check("R1 done", done_o, 0);
    check("R1 ovf", ovf_o, 0);
    check("R1 selects", {sel_in_o, sel_ref_o}, 0);
    check("R1 int reset", int_rst_o, 1);
    check("R1 result", result_o, 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int v = 0; v <= 20; v++) convert(v, 0);
    convert(5000, 0);
    convert(99, 0);
    convert(1234, 0);
    convert(9998, 0);
    convert(9999, 0);
    convert(10000, 0);

    cmp_force = 1'b1;
    repeat (5) @(negedge clk);
    cmp_force = 1'b0;
    repeat (5) @(negedge clk);
    check("R9 ovf held while idle", ovf_o, 1);
    check("R9 result held while idle", result_o, bcd(9999));

    convert(12000, 0);
    convert(321, 1);
    convert(7, 0);
    check("R10 digit split", result_o[3:0], 7);
    finish_run();
  end
endmodule